// File: doc/BRIEF.md
# Fractional Clock Divider with Accumulator-Driven Divisor Choice

This block takes a fast reference clock and produces a much slower output clock together with a one-cycle enable pulse. The output frequency can be a fraction of the reference, not only an integer divisor. An unsigned increment word is added into a phase accumulator of `ACC_W` bits. The average output frequency is the reference frequency times the increment divided by 2^ACC_W. The increment can be changed while the block runs.

Two variants are chosen at build time by the `MODE` parameter. In the accumulator variant the accumulator adds the increment on every reference cycle, and its top bit, registered, is the output clock. In the dual-modulus variant a period counter runs output periods of `DIV_N` or `DIV_N`+1 reference cycles. The accumulator steps once per period, and its carry picks the longer length for the period that starts at that step. With `DIV_N` = 812, a 21-bit accumulator and an increment of 2^20, a 13 MHz reference gives periods that alternate between 812 and 813 cycles, which is 16 kHz on average. Downstream logic on the same clock uses `tick_o` as a clock enable.

Top module: `frac_clk_div`

## Requirements
- R1: A synchronous reset clears the accumulator, the period counter, `tick_o` and `clk_o`. After any clock edge taken with `rst` high, both outputs read 0. This holds whether the block was idle or running before the reset.
- R2: Accumulator variant: `clk_o` is the accumulator's top bit delayed by one register. For an increment N with 0 < N < 2^(ACC_W-1), held constant, any window of 2^ACC_W consecutive reference cycles contains exactly N output ticks.
- R3: `tick_o` is high for exactly one reference cycle, and only in the cycle where `clk_o` rises. The number of `tick_o` pulses equals the number of `clk_o` rising edges.
- R4: Dual-modulus variant: the spacing between consecutive `tick_o` pulses is always `DIV_N` or `DIV_N`+1 cycles. A period is `DIV_N`+1 long exactly when the accumulator step made at its start carries out of bit ACC_W-1.
- R5: Dual-modulus variant: with a constant increment N (0 <= N < 2^ACC_W), any 2^ACC_W consecutive output periods contain exactly N periods of length `DIV_N`+1.
- R6: Dual-modulus variant: `clk_o` is high for the first floor(`DIV_N`/2) cycles of each period, starting in the `tick_o` cycle, and low for the rest of the period.
- R7: The increment word is sampled only while in reset and at output period boundaries. In the accumulator variant a boundary is an accumulator wrap. In the dual-modulus variant a boundary is a `tick_o` cycle, and the sampled value is first used at the following boundary.
- R8: An increment of zero gives no ticks and a constant-low `clk_o` in the accumulator variant, and only `DIV_N`-cycle periods in the dual-modulus variant.
- R9: Dual-modulus variant: the first `tick_o` comes on the first clock edge after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| incr | input | ACC_W | Unsigned phase increment word |
| tick_o | output | 1 | One-cycle enable pulse at each output rising edge |
| clk_o | output | 1 | Divided output clock, registered |

## Verification
A table of increments runs through both variants at once: zero, one, small odd values, a power of two and the largest legal value. For each increment the bench counts ticks over one full accumulator cycle and counts the periods of length n+1 over 2^ACC_W periods. Together these show that the fraction is realised exactly, that clock edges and ticks agree, and that a zero increment degenerates correctly. Directed runs change the increment right after reset, and the positions of the ticks that follow show whether the new word was taken immediately or only at the next boundary. A further run checks the high and low phase pattern of the dual-modulus clock and its first tick after reset.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  typedef enum logic {
    FDIV_ACC = 1'b0,  // accumulator top bit is the output clock
    FDIV_NN1 = 1'b1   // n / n+1 period counter steered by accumulator carry
  } fdiv_mode_e;
endpackage

// File: rtl/fdiv_phase_acc.sv
module fdiv_phase_acc #(
  parameter int ACC_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             reload,
  input  logic [ACC_W-1:0] incr,
  output logic             acc_msb,
  output logic             carry
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] inc_q;
  logic [ACC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, inc_q};
  assign carry   = step & sum[ACC_W];
  assign acc_msb = acc_q[ACC_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      inc_q <= incr;
    end else begin
      if (step)   acc_q <= sum[ACC_W-1:0];
      if (reload) inc_q <= incr;
    end
  end

  // R7: the held increment only moves at a period boundary
  p_inc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !reload |=> $stable(inc_q));

  // R2: without a step the phase does not move
  p_acc_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(acc_q));
endmodule

// File: rtl/fdiv_period.sv
module fdiv_period #(
  parameter int DIV_N = 812
) (
  input  logic clk,
  input  logic rst,
  input  logic long_sel,
  output logic boundary,
  output logic high_nxt
);
  localparam int CNT_W    = $clog2(DIV_N + 1);
  localparam int HIGH_LEN = DIV_N / 2;

  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] pos_nxt;

  assign boundary = (pos_q == last_q);
  assign pos_nxt  = boundary ? '0 : pos_q + 1'b1;
  assign high_nxt = (pos_nxt < CNT_W'(HIGH_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      last_q <= '0;
    end else begin
      pos_q <= pos_nxt;
      if (boundary) last_q <= long_sel ? CNT_W'(DIV_N) : CNT_W'(DIV_N - 1);
    end
  end

  // R4: position never runs past the end of the current period
  p_pos_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    pos_q <= last_q);

  // R4: every period chosen is n or n+1 cycles long
  p_len_choice_r4: assert property (@(posedge clk) disable iff (rst)
    boundary |=> (last_q == CNT_W'(DIV_N) || last_q == CNT_W'(DIV_N - 1)));
endmodule

// File: rtl/fdiv_outreg.sv
module fdiv_outreg (
  input  logic clk,
  input  logic rst,
  input  logic tick_d,
  input  logic clk_d,
  output logic tick_o,
  output logic clk_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tick_o <= 1'b0;
      clk_o  <= 1'b0;
    end else begin
      tick_o <= tick_d;
      clk_o  <= clk_d;
    end
  end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int                   ACC_W = 21,
  parameter fdiv_pkg::fdiv_mode_e MODE  = fdiv_pkg::FDIV_ACC,
  parameter int                   DIV_N = 812
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] incr,
  output logic             tick_o,
  output logic             clk_o
);
  logic tick_d;
  logic clk_d;

  generate
    if (MODE == fdiv_pkg::FDIV_ACC) begin : g_acc
      logic msb;
      logic wrap;
      fdiv_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst(rst), .step(1'b1), .reload(wrap), .incr(incr),
        .acc_msb(msb), .carry(wrap)
      );
      assign clk_d  = msb;
      assign tick_d = msb & ~clk_o;
    end else begin : g_nn1
      logic bnd;
      logic long_sel;
      logic high_nxt;
      logic msb_unused;
      fdiv_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst(rst), .step(bnd), .reload(bnd), .incr(incr),
        .acc_msb(msb_unused), .carry(long_sel)
      );
      fdiv_period #(.DIV_N(DIV_N)) u_per (
        .clk(clk), .rst(rst), .long_sel(long_sel),
        .boundary(bnd), .high_nxt(high_nxt)
      );
      assign clk_d  = high_nxt;
      assign tick_d = bnd;
    end
  endgenerate

  fdiv_outreg u_out (
    .clk(clk), .rst(rst), .tick_d(tick_d), .clk_d(clk_d),
    .tick_o(tick_o), .clk_o(clk_o)
  );

  // R1: outputs are low after any edge taken in reset
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> (!tick_o && !clk_o));

  // R3: tick lasts a single cycle
  p_tick_single_r3: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  // R3: tick marks a rising edge of the output clock
  p_tick_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $rose(clk_o));
endmodule

// File: tb/sim_frac_clk_div.sv
module sim_frac_clk_div;
  localparam int ACC_W = 8;
  localparam int DIV_N = 4;
  localparam int WIN   = 1 << ACC_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ACC_W-1:0] incr0 = '0;
  logic [ACC_W-1:0] incr1 = '0;
  logic tick0, clk0, tick1, clk1;

  int nchk  = 0;
  int nfail = 0;

  always #2 clk = ~clk;  // 250 MHz

  frac_clk_div #(.ACC_W(ACC_W), .MODE(fdiv_pkg::FDIV_ACC), .DIV_N(DIV_N)) u0 (
    .clk(clk), .rst(rst), .incr(incr0), .tick_o(tick0), .clk_o(clk0)
  );
  frac_clk_div #(.ACC_W(ACC_W), .MODE(fdiv_pkg::FDIV_NN1), .DIV_N(DIV_N)) u1 (
    .clk(clk), .rst(rst), .incr(incr1), .tick_o(tick1), .clk_o(clk1)
  );

  // increment, expected count (R2 ticks in mode 0, R5 long periods in mode 1)
  localparam int NVEC = 7;
  localparam int VEC [NVEC][2] = '{
    '{0, 0}, '{1, 1}, '{5, 5}, '{37, 37}, '{64, 64}, '{100, 100}, '{127, 127}
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int i0, input int i1);
    @(negedge clk);
    rst   = 1'b1;
    incr0 = ACC_W'(i0);
    incr1 = ACC_W'(i1);
    @(negedge clk);
    @(negedge clk);
    // R1: outputs cleared by reset, whatever ran before
    chk("R1 tick mode0", int'(tick0), 0);
    chk("R1 clk mode0",  int'(clk0),  0);
    chk("R1 tick mode1", int'(tick1), 0);
    chk("R1 clk mode1",  int'(clk1),  0);
  endtask

  initial begin
    #(4 * 200000);
    nfail++;
    nchk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    // table walk
    for (int v = 0; v < NVEC; v++) begin
      int cnt0, rise0, prev0, last1, nper, nlong, nbad;
      do_reset(VEC[v][0], VEC[v][0]);
      rst = 1'b0;
      cnt0 = 0; rise0 = 0; prev0 = 0; last1 = 0; nper = 0; nlong = 0; nbad = 0;
      for (int e = 1; e <= 1400; e++) begin
        @(negedge clk);
        if (e <= WIN) begin
          if (tick0) cnt0++;
          if (clk0 && prev0 == 0) rise0++;
        end
        prev0 = int'(clk0);
        if (tick1) begin
          if (last1 > 0 && nper < WIN) begin
            if (e - last1 == DIV_N + 1) nlong++;
            else if (e - last1 != DIV_N) nbad++;
            nper++;
          end
          last1 = e;
        end
      end
      chk("R2 ticks per window", cnt0, VEC[v][1]);      // R8 when zero
      chk("R3 ticks equal clk rises", rise0, cnt0);
      chk("R4 periods outside n..n+1", nbad, 0);
      chk("R4 periods observed", nper, WIN);
      chk("R5 long periods", nlong, VEC[v][1]);          // R8 when zero
    end

    // R7 / R9: increment changes just after reset
    begin
      int t0 [2];
      int t1 [4];
      int n0, n1;
      do_reset(16, 0);
      rst = 1'b0;
      incr0 = ACC_W'(112);
      incr1 = ACC_W'(128);
      n0 = 0; n1 = 0;
      for (int e = 1; e <= 20; e++) begin
        @(negedge clk);
        if (tick0 && n0 < 2) begin t0[n0] = e; n0++; end
        if (tick1 && n1 < 4) begin t1[n1] = e; n1++; end
      end
      chk("R7 mode0 first tick", t0[0], 9);
      chk("R7 mode0 second tick", t0[1], 19);
      chk("R9 mode1 first tick", t1[0], 1);
      chk("R7 mode1 second tick", t1[1], 5);
      chk("R7 mode1 third tick", t1[2], 9);
      chk("R7 mode1 fourth tick", t1[3], 14);
    end

    // R6 / R4: clock shape in dual-modulus mode, increment of one half
    begin
      int exp_clk [9] = '{1, 1, 0, 0, 1, 1, 0, 0, 0};
      int exp_tk  [9] = '{1, 0, 0, 0, 1, 0, 0, 0, 0};
      do_reset(0, 128);
      rst = 1'b0;
      for (int e = 1; e <= 9; e++) begin
        @(negedge clk);
        chk($sformatf("R6 clk_o at edge %0d", e), int'(clk1), exp_clk[e-1]);
        chk($sformatf("R4 tick_o at edge %0d", e), int'(tick1), exp_tk[e-1]);
      end
      @(negedge clk);
      chk("R4 long period tick at edge 10", int'(tick1), 1);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule